// File: doc/BRIEF.md
# Program Page Window Translator

This block widens a 16-bit CPU address into a 20-bit physical program address. A 6-bit page index register picks one of 64 pages of 16 KB each, so up to 1 MB of program memory can be reached. CPU addresses inside the fixed window 0x8000..0xBFFF are remapped: the two upper address bits are replaced with the page index. The other three 16 KB regions of the CPU map go to fixed default pages, so every access yields a 20-bit address.

The index is held in a byte-wide register on a small register bus, at offset 0x30 from the register block base. Reads are always allowed. Two parameters fixed at integration decide whether writes are allowed: either in every mode, or only in special mode. The reset value is tied to that choice. A second port, used by a far call/return sequencer, reads the index at all times and can overwrite it whatever the write policy. The address path is a valid/ready stream with no storage. The translated address comes out in the same cycle as the CPU address. Back-pressure from the downstream side reaches the CPU unchanged: `cpu_ready` follows `phys_ready` and `phys_valid` follows `cpu_valid`. A request is taken on any cycle where both valid and ready are high.

Top module: `page_window_xlate`

## Requirements
- R1: After reset the index is 0x3C when the special-only write policy is chosen (SPECIAL_ONLY=1), and 0x00 when the write-anytime policy is chosen (SPECIAL_ONLY=0).
- R2: A CPU address with bits [15:14] = 2'b10 (0x8000..0xBFFF) translates to `phys_addr = {index, cpu_addr[13:0]}`, in the same cycle.
- R3: Addresses outside the window map to fixed pages: bits [15:14]=00 to page 0x3D, 01 to page 0x3E, 11 to page 0x3F. In each case `phys_addr = {page, cpu_addr[13:0]}`.
- R4: A register write (`reg_sel`=1, `reg_wr`=1, `reg_addr`=0x30) that is permitted loads `reg_wdata[5:0]` at the clock edge that ends the write cycle. Translation in the write cycle still uses the old index, and the new index applies from the next cycle on. Data bits 7:6 are dropped.
- R5: A register write to any offset other than 0x30 leaves the index unchanged.
- R6: Under SPECIAL_ONLY=1, a register write while `special_mode`=0 leaves the index unchanged. `wr_ignored` is then high for exactly the one cycle that follows the write. Under SPECIAL_ONLY=0, writes are never blocked and `wr_ignored` stays 0.
- R7: `far_wr`=1 loads `far_wdata` into the index at the next clock edge, whatever the policy and mode. It takes priority over a register write in the same cycle. `far_index` always shows the current index.
- R8: With `reg_sel`=1 and `reg_addr`=0x30, `reg_rdata` = {2'b00, index} in any mode. Otherwise `reg_rdata` is 0x00.
- R9: `phys_valid` equals `cpu_valid` and `cpu_ready` equals `phys_ready` in every cycle. The translator neither holds nor drops requests.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| special_mode | input | 1 | Chip is in special (test/debug) mode |
| reg_sel | input | 1 | Register block select |
| reg_wr | input | 1 | Register write strobe (read when low) |
| reg_addr | input | 8 | Register offset from block base |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| wr_ignored | output | 1 | One-cycle pulse after a blocked write |
| far_wr | input | 1 | Side port index update strobe |
| far_wdata | input | 6 | Side port new index |
| far_index | output | 6 | Side port view of current index |
| cpu_valid | input | 1 | CPU address valid |
| cpu_ready | output | 1 | Translator can accept CPU address |
| cpu_addr | input | 16 | CPU logical address |
| phys_valid | output | 1 | Physical address valid |
| phys_ready | input | 1 | Downstream accepts physical address |
| phys_addr | output | 20 | Translated physical address |

## Verification
The bench builds two instances side by side on the same stimulus. `u0` uses SPECIAL_ONLY=1, so it resets to 0x3C and blocks writes outside special mode. `u1` uses SPECIAL_ONLY=0, so it resets to 0x00 and accepts every write. Running both at once checks both reset values and both policy branches, and shows that the same blocked write lands in one instance and not the other. It also shows that the side port overrides the policy only where the policy bites.

// File: rtl/pwx_pkg.sv
package pwx_pkg;

  // Regions of the CPU map, indexed by the top two address bits.
  localparam int unsigned NUM_REGIONS = 4;
  localparam int unsigned WIN_REGION  = 2;

  // Default page for a non-window region: the last pages of the physical space.
  function automatic int unsigned fixed_page(input int unsigned region,
                                             input int unsigned idx_w);
    int unsigned top;
    top = (1 << idx_w) - 1;
    case (region)
      0:       fixed_page = top - 2;
      1:       fixed_page = top - 1;
      default: fixed_page = top;
    endcase
  endfunction

  // Reset value tied to the write policy.
  function automatic int unsigned reset_index(input bit special_only);
    reset_index = special_only ? 32'h3C : 32'h00;
  endfunction

endpackage

// File: rtl/pwx_bus_decode.sv
module pwx_bus_decode #(
  parameter int unsigned REG_AW     = 8,
  parameter int unsigned REG_DW     = 8,
  parameter int unsigned IDX_W      = 6,
  parameter int unsigned REG_OFFSET = 8'h30
) (
  input  logic              reg_sel,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  input  logic [IDX_W-1:0]  cur_index,
  output logic              wr_req,
  output logic [IDX_W-1:0]  wr_index,
  output logic [REG_DW-1:0] reg_rdata
);

  localparam int unsigned PAD_W = REG_DW - IDX_W;

  logic hit;

  always_comb begin
    hit      = reg_sel && (reg_addr == REG_AW'(REG_OFFSET));
    wr_req   = hit && reg_wr;
    wr_index = reg_wdata[IDX_W-1:0];
    if (hit) reg_rdata = {{PAD_W{1'b0}}, cur_index};
    else     reg_rdata = '0;
  end

endmodule

// File: rtl/pwx_index_reg.sv
module pwx_index_reg #(
  parameter int unsigned IDX_W        = 6,
  parameter bit          SPECIAL_ONLY = 1'b0,
  parameter int unsigned RESET_INDEX  = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             special_mode,
  input  logic             bus_wr_req,
  input  logic [IDX_W-1:0] bus_wr_index,
  input  logic             far_wr,
  input  logic [IDX_W-1:0] far_wdata,
  output logic [IDX_W-1:0] index_q,
  output logic             wr_ignored
);

  logic allowed;

  generate
    if (SPECIAL_ONLY) begin : g_special_only
      assign allowed = special_mode;
    end else begin : g_any_mode
      assign allowed = 1'b1;
    end
  endgenerate

  logic blocked;
  assign blocked = bus_wr_req && !allowed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      index_q    <= IDX_W'(RESET_INDEX);
      wr_ignored <= 1'b0;
    end else begin
      wr_ignored <= blocked;
      if (far_wr)
        index_q <= far_wdata;
      else if (bus_wr_req && allowed)
        index_q <= bus_wr_index;
    end
  end

endmodule

// File: rtl/pwx_window_map.sv
module pwx_window_map
  import pwx_pkg::*;
#(
  parameter int unsigned IDX_W  = 6,
  parameter int unsigned CPU_AW = 16
) (
  input  logic [IDX_W-1:0]          cur_index,
  input  logic [CPU_AW-1:0]         cpu_addr,
  output logic [IDX_W+CPU_AW-3:0]   phys_addr
);

  localparam int unsigned OFS_W = CPU_AW - 2;

  logic [IDX_W-1:0] page_of [NUM_REGIONS];

  genvar r;
  generate
    for (r = 0; r < NUM_REGIONS; r++) begin : g_region
      if (r == WIN_REGION) begin : g_win
        assign page_of[r] = cur_index;
      end else begin : g_fixed
        assign page_of[r] = IDX_W'(fixed_page(r, IDX_W));
      end
    end
  endgenerate

  logic [1:0] region;
  assign region    = cpu_addr[CPU_AW-1 -: 2];
  assign phys_addr = {page_of[region], cpu_addr[OFS_W-1:0]};

endmodule

// File: rtl/page_window_xlate.sv
module page_window_xlate
  import pwx_pkg::*;
#(
  parameter int unsigned IDX_W        = 6,
  parameter int unsigned CPU_AW       = 16,
  parameter int unsigned REG_AW       = 8,
  parameter int unsigned REG_DW       = 8,
  parameter int unsigned REG_OFFSET   = 8'h30,
  parameter bit          SPECIAL_ONLY = 1'b1,
  parameter int unsigned PHYS_AW      = IDX_W + CPU_AW - 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               special_mode,
  input  logic               reg_sel,
  input  logic               reg_wr,
  input  logic [REG_AW-1:0]  reg_addr,
  input  logic [REG_DW-1:0]  reg_wdata,
  output logic [REG_DW-1:0]  reg_rdata,
  output logic               wr_ignored,
  input  logic               far_wr,
  input  logic [IDX_W-1:0]   far_wdata,
  output logic [IDX_W-1:0]   far_index,
  input  logic               cpu_valid,
  output logic               cpu_ready,
  input  logic [CPU_AW-1:0]  cpu_addr,
  output logic               phys_valid,
  input  logic               phys_ready,
  output logic [PHYS_AW-1:0] phys_addr
);

  localparam int unsigned RESET_INDEX = reset_index(SPECIAL_ONLY);

  logic             bus_wr_req;
  logic [IDX_W-1:0] bus_wr_index;
  logic [IDX_W-1:0] index_q;

  pwx_bus_decode #(
    .REG_AW(REG_AW), .REG_DW(REG_DW), .IDX_W(IDX_W), .REG_OFFSET(REG_OFFSET)
  ) u_dec (
    .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .cur_index(index_q),
    .wr_req(bus_wr_req), .wr_index(bus_wr_index), .reg_rdata(reg_rdata)
  );

  pwx_index_reg #(
    .IDX_W(IDX_W), .SPECIAL_ONLY(SPECIAL_ONLY), .RESET_INDEX(RESET_INDEX)
  ) u_idx (
    .clk(clk), .rst_n(rst_n), .special_mode(special_mode),
    .bus_wr_req(bus_wr_req), .bus_wr_index(bus_wr_index),
    .far_wr(far_wr), .far_wdata(far_wdata),
    .index_q(index_q), .wr_ignored(wr_ignored)
  );

  pwx_window_map #(.IDX_W(IDX_W), .CPU_AW(CPU_AW)) u_map (
    .cur_index(index_q), .cpu_addr(cpu_addr), .phys_addr(phys_addr)
  );

  // Pure combinational stream stage: no storage on the address path.
  assign phys_valid = cpu_valid;
  assign cpu_ready  = phys_ready;
  assign far_index  = index_q;

endmodule

// File: rtl/page_window_xlate_chk.sv
module page_window_xlate_chk #(
  parameter int unsigned IDX_W        = 6,
  parameter int unsigned CPU_AW       = 16,
  parameter int unsigned REG_AW       = 8,
  parameter int unsigned REG_DW       = 8,
  parameter int unsigned REG_OFFSET   = 8'h30,
  parameter bit          SPECIAL_ONLY = 1'b1,
  parameter int unsigned PHYS_AW      = IDX_W + CPU_AW - 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               special_mode,
  input logic               reg_sel,
  input logic               reg_wr,
  input logic [REG_AW-1:0]  reg_addr,
  input logic [REG_DW-1:0]  reg_wdata,
  input logic [REG_DW-1:0]  reg_rdata,
  input logic               wr_ignored,
  input logic               far_wr,
  input logic [IDX_W-1:0]   far_wdata,
  input logic [IDX_W-1:0]   far_index,
  input logic               cpu_valid,
  input logic               cpu_ready,
  input logic [CPU_AW-1:0]  cpu_addr,
  input logic               phys_valid,
  input logic               phys_ready,
  input logic [PHYS_AW-1:0] phys_addr
);

  logic bus_hit, ok_wr, bad_wr;
  assign bus_hit = reg_sel && reg_wr && (reg_addr == REG_AW'(REG_OFFSET));
  assign ok_wr   = bus_hit && (!SPECIAL_ONLY || special_mode);
  assign bad_wr  = bus_hit && SPECIAL_ONLY && !special_mode;

  assert_window_map_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[CPU_AW-1 -: 2] == 2'b10) |->
      (phys_addr == {far_index, cpu_addr[CPU_AW-3:0]}));

  assert_fixed_top_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[CPU_AW-1 -: 2] == 2'b11) |->
      (phys_addr[PHYS_AW-1 -: IDX_W] == {IDX_W{1'b1}}));

  assert_bus_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ok_wr && !far_wr) |=> (far_index == $past(reg_wdata[IDX_W-1:0])));

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_hit && !far_wr) |=> $stable(far_index));

  assert_blocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_wr && !far_wr) |=> ($stable(far_index) && wr_ignored));

  assert_flag_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !bad_wr |=> !wr_ignored);

  assert_far_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    far_wr |=> (far_index == $past(far_wdata)));

  assert_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[REG_DW-1:IDX_W] == '0);

  assert_stream_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (phys_valid == cpu_valid) && (cpu_ready == phys_ready));

endmodule

bind page_window_xlate page_window_xlate_chk #(
  .IDX_W(IDX_W), .CPU_AW(CPU_AW), .REG_AW(REG_AW), .REG_DW(REG_DW),
  .REG_OFFSET(REG_OFFSET), .SPECIAL_ONLY(SPECIAL_ONLY), .PHYS_AW(PHYS_AW)
) u_chk (.*);

// File: tb/sim_page_window_xlate.sv
`timescale 1ns/1ps
module sim_page_window_xlate;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic special_mode = 1'b0, reg_sel = 1'b0, reg_wr = 1'b0;
  logic [7:0] reg_addr = '0, reg_wdata = '0;
  logic far_wr = 1'b0;
  logic [5:0] far_wdata = '0;
  logic cpu_valid = 1'b0, phys_ready = 1'b0;
  logic [15:0] cpu_addr = '0;

  logic [7:0]  rd0, rd1;
  logic        ig0, ig1, rdy0, rdy1, pv0, pv1;
  logic [5:0]  fi0, fi1;
  logic [19:0] pa0, pa1;

  int total = 0, bad = 0;
  bit done = 1'b0;
  logic [5:0] exp0, exp1;

  always #(CLK_PERIOD/2) clk = ~clk;

  page_window_xlate #(.SPECIAL_ONLY(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .special_mode(special_mode),
    .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(rd0), .wr_ignored(ig0),
    .far_wr(far_wr), .far_wdata(far_wdata), .far_index(fi0),
    .cpu_valid(cpu_valid), .cpu_ready(rdy0), .cpu_addr(cpu_addr),
    .phys_valid(pv0), .phys_ready(phys_ready), .phys_addr(pa0));

  page_window_xlate #(.SPECIAL_ONLY(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .special_mode(special_mode),
    .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(rd1), .wr_ignored(ig1),
    .far_wr(far_wr), .far_wdata(far_wdata), .far_index(fi1),
    .cpu_valid(cpu_valid), .cpu_ready(rdy1), .cpu_addr(cpu_addr),
    .phys_valid(pv1), .phys_ready(phys_ready), .phys_addr(pa1));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Read the index through the register bus (combinational read).
  task automatic read_back(input string tag);
    @(negedge clk);
    reg_sel = 1'b1; reg_wr = 1'b0; reg_addr = 8'h30;
    #1;
    chk({tag, " u0 rdata"}, rd0, {2'b00, exp0});
    chk({tag, " u1 rdata"}, rd1, {2'b00, exp1});
    reg_sel = 1'b0;
  endtask

  task automatic bus_write(input logic [7:0] ofs, input logic [7:0] d, input logic spec);
    @(negedge clk);
    reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = ofs; reg_wdata = d; special_mode = spec;
    @(negedge clk);
    reg_sel = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic t_reset;
    exp0 = 6'h3C; exp1 = 6'h00;
    chk("R1 u0 reset index", fi0, 6'h3C);
    chk("R1 u1 reset index", fi1, 6'h00);
    chk("R6 reset wr_ignored", {ig0, ig1}, 2'b00);
    read_back("R1/R8");
  endtask

  task automatic t_window;
    logic [15:0] addrs [3] = '{16'h8000, 16'hBFFF, 16'h9A5C};
    foreach (addrs[i]) begin
      @(negedge clk); cpu_addr = addrs[i]; #1;
      chk("R2 u0 window", pa0, {exp0, addrs[i][13:0]});
      chk("R2 u1 window", pa1, {exp1, addrs[i][13:0]});
    end
  endtask

  task automatic t_outside;
    @(negedge clk); cpu_addr = 16'h0123; #1;
    chk("R3 region0", pa0, {6'h3D, 14'h0123});
    cpu_addr = 16'h7FFF; #1;
    chk("R3 region1", pa0, {6'h3E, 14'h3FFF});
    cpu_addr = 16'h4000; #1;
    chk("R3 region1 low", pa1, {6'h3E, 14'h0000});
    cpu_addr = 16'hC001; #1;
    chk("R3 region3", pa0, {6'h3F, 14'h0001});
    chk("R3 region3 u1", pa1, {6'h3F, 14'h0001});
  endtask

  task automatic t_write_timing;
    cpu_addr = 16'h8004;
    @(negedge clk);
    reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = 8'h30; reg_wdata = 8'hD5; special_mode = 1'b1;
    #1;
    chk("R4 old index in write cycle", pa0, {exp0, 14'h0004});
    @(negedge clk);
    reg_sel = 1'b0; reg_wr = 1'b0;
    exp0 = 6'h15; exp1 = 6'h15;
    #1;
    chk("R4 new index next cycle u0", pa0, {6'h15, 14'h0004});
    chk("R4 new index next cycle u1", pa1, {6'h15, 14'h0004});
    chk("R4 high bits dropped", fi0, 6'h15);
    read_back("R4/R8");
  endtask

  task automatic t_other_offset;
    bus_write(8'h31, 8'h0A, 1'b1);
    chk("R5 offset 0x31 u0", fi0, exp0);
    bus_write(8'h10, 8'h0B, 1'b1);
    chk("R5 offset 0x10 u1", fi1, exp1);
    @(negedge clk);
    reg_sel = 1'b1; reg_wr = 1'b0; reg_addr = 8'h2F; #1;
    chk("R8 other offset reads zero", rd0, 8'h00);
    reg_sel = 1'b0;
  endtask

  task automatic t_policy;
    bus_write(8'h30, 8'h27, 1'b0);
    exp1 = 6'h27;
    chk("R6 u0 blocked index", fi0, exp0);
    chk("R6 u0 wr_ignored pulse", ig0, 1'b1);
    chk("R6 u1 accepts", fi1, 6'h27);
    chk("R6 u1 no flag", ig1, 1'b0);
    @(negedge clk);
    chk("R6 pulse one cycle", ig0, 1'b0);
    read_back("R6/R8 non-special");
    bus_write(8'h30, 8'h08, 1'b1);
    exp0 = 6'h08; exp1 = 6'h08;
    chk("R6 u0 special accepts", fi0, 6'h08);
    chk("R6 u0 no flag special", ig0, 1'b0);
  endtask

  task automatic t_far;
    @(negedge clk);
    special_mode = 1'b0; far_wr = 1'b1; far_wdata = 6'h2A;
    @(negedge clk);
    far_wr = 1'b0; exp0 = 6'h2A; exp1 = 6'h2A;
    chk("R7 far write u0 non-special", fi0, 6'h2A);
    chk("R7 far write u1", fi1, 6'h2A);
    // Collision with a permitted bus write: side port wins.
    @(negedge clk);
    special_mode = 1'b1; far_wr = 1'b1; far_wdata = 6'h01;
    reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = 8'h30; reg_wdata = 8'h3E;
    @(negedge clk);
    far_wr = 1'b0; reg_sel = 1'b0; reg_wr = 1'b0;
    exp0 = 6'h01; exp1 = 6'h01;
    chk("R7 priority u0", fi0, 6'h01);
    chk("R7 priority u1", fi1, 6'h01);
    cpu_addr = 16'hA000; #1;
    chk("R7/R2 window follows far write", pa0, {6'h01, 14'h2000});
  endtask

  task automatic t_stream;
    @(negedge clk);
    cpu_valid = 1'b1; phys_ready = 1'b0; #1;
    chk("R9 valid pass", {pv0, pv1}, 2'b11);
    chk("R9 stall", {rdy0, rdy1}, 2'b00);
    phys_ready = 1'b1; #1;
    chk("R9 ready pass", {rdy0, rdy1}, 2'b11);
    cpu_valid = 1'b0; #1;
    chk("R9 idle", {pv0, pv1}, 2'b00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_window();
    t_outside();
    t_write_timing();
    t_window();
    t_other_offset();
    t_policy();
    t_far();
    t_stream();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule